// File: doc/BRIEF.md
# Vector Shift-and-Insert Unit

This unit produces the new value of a vector destination register for the two "shift with insert" operations. Every lane of the source vector is shifted by an immediate amount. The bit positions that the shift empties are not filled with zeros or sign bits. They take the matching bits of the old destination lane, so the new lane mixes shifted source bits with preserved destination bits.

The caller supplies the source, the old destination, a lane-size code, the immediate, the direction, a 64/128-bit width select and a scalar flag. The merged vector appears on the output one clock later.

In a left insert, the destination keeps its low bits under the shifted source. In a right insert, it keeps its high bits above the shifted source. In 64-bit mode the upper half of the result is zero. In scalar mode only lane 0 is produced.

Top module: `vsi_unit`

## Requirements
- R1: Left insert (`shiftRight`=0), immediate n with 0 <= n < lane width L: result lane = ((src lane << n) mod 2^L) | (dst lane mod 2^n).
- R2: A left insert with n = 0 returns the source lane unchanged; no destination bit survives.
- R3: Right insert (`shiftRight`=1), immediate n with 1 <= n <= L: result lane = (src lane >> n, logical) | (the top n bits of the dst lane, kept in place).
- R4: A right insert with n equal to the lane width returns the destination lane unchanged, for every lane size.
- R5: `laneCode` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lanes are independent, and no bit of one lane affects another.
- R6: With `wide`=0 (64-bit mode) and `scalarMode`=0, only the low 64 bits are processed and result bits 127:64 are zero.
- R7: With `scalarMode`=1, only lane 0 (bits L-1:0) is produced, and every other result bit, including bits 127:64, is zero, whatever `wide` is.
- R8: `resultVec` is registered. It reflects the inputs present at the previous rising clock edge, and it is all zeros while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcVec | input | 128 | Source vector to be shifted |
| dstVec | input | 128 | Old destination vector supplying the preserved bits |
| laneCode | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| shiftImm | input | 7 | Shift immediate |
| shiftRight | input | 1 | 0 = left insert, 1 = right insert |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| scalarMode | input | 1 | 1 = produce lane 0 only |
| resultVec | output | 128 | Merged destination value |

## Verification
Two functions can act on the same bits in one cycle: the per-lane merge and the clearing of unused lanes by width or scalar mode. The most telling overlap is a right insert by the full lane width, which must return the destination lane unchanged, while 64-bit or scalar mode zeroes the rest of the vector. The bench sweeps every lane size, both directions, every legal immediate, all three width modes and three data patterns, including all-ones and all-zeros operands. It judges each result against a lane-by-lane arithmetic model that uses division and modulo rather than masks.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;
  localparam int MAX_LANE  = MIN_LANE << (NUM_SIZES - 1);
  localparam int CODE_W    = $clog2(NUM_SIZES);
  localparam int SHIFT_W   = $clog2(MAX_LANE) + 1;
  localparam int BYTES     = VEC_W / 8;

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeHot;  // one-hot lane width
    logic                 toRight;  // right insert when set
    logic [SHIFT_W-1:0]   amt;      // shift amount
    logic [BYTES-1:0]     byteEn;   // result bytes that are kept
  } vsi_strobe_t;
endpackage

// File: rtl/vsi_ctrl.sv
module vsi_ctrl
  import vsi_pkg::*;
(
  input  logic [CODE_W-1:0]  laneCode,
  input  logic [SHIFT_W-1:0] shiftImm,
  input  logic               shiftRight,
  input  logic               wide,
  input  logic               scalarMode,
  output vsi_strobe_t        strobes
);
  localparam int HALF_BYTES = HALF_W / 8;

  logic [4:0] laneBytes;

  always_comb begin
    laneBytes = 5'd1 << laneCode;
    strobes.sizeHot = '0;
    strobes.sizeHot[laneCode] = 1'b1;
    strobes.toRight = shiftRight;
    strobes.amt     = shiftImm;
    for (int b = 0; b < BYTES; b++) begin
      if (scalarMode)
        strobes.byteEn[b] = (b < int'(laneBytes));
      else if (!wide)
        strobes.byteEn[b] = (b < HALF_BYTES);
      else
        strobes.byteEn[b] = 1'b1;
    end
  end
endmodule

// File: rtl/vsi_lanes.sv
module vsi_lanes
  import vsi_pkg::*;
(
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstVec,
  input  vsi_strobe_t      strobes,
  output logic [VEC_W-1:0] mergedVec
);
  logic [VEC_W-1:0] variants [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
    localparam int LW = MIN_LANE << g;
    localparam int NL = VEC_W / LW;
    logic [VEC_W-1:0] laneOut;
    for (genvar i = 0; i < NL; i++) begin : gLane
      logic [LW-1:0] s, d, ones, lowMask, highMask, leftVal, rightVal;
      assign s        = srcVec[i*LW +: LW];
      assign d        = dstVec[i*LW +: LW];
      assign ones     = '1;
      assign lowMask  = ~(ones << strobes.amt);
      assign highMask = ~(ones >> strobes.amt);
      assign leftVal  = (s << strobes.amt) | (d & lowMask);
      assign rightVal = (s >> strobes.amt) | (d & highMask);
      assign laneOut[i*LW +: LW] = strobes.toRight ? rightVal : leftVal;
    end
    assign variants[g] = laneOut;
  end

  logic [VEC_W-1:0] picked, byteMask;

  always_comb begin
    picked = '0;
    for (int g = 0; g < NUM_SIZES; g++)
      if (strobes.sizeHot[g]) picked = picked | variants[g];
    for (int b = 0; b < BYTES; b++)
      byteMask[b*8 +: 8] = {8{strobes.byteEn[b]}};
    mergedVec = picked & byteMask;
  end
endmodule

// File: rtl/vsi_unit.sv
module vsi_unit
  import vsi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   dstVec,
  input  logic [CODE_W-1:0]  laneCode,
  input  logic [SHIFT_W-1:0] shiftImm,
  input  logic               shiftRight,
  input  logic               wide,
  input  logic               scalarMode,
  output logic [VEC_W-1:0]   resultVec
);
  vsi_strobe_t      strobes;
  logic [VEC_W-1:0] mergedVec;

  vsi_ctrl u_ctrl (
    .laneCode   (laneCode),
    .shiftImm   (shiftImm),
    .shiftRight (shiftRight),
    .wide       (wide),
    .scalarMode (scalarMode),
    .strobes    (strobes)
  );

  vsi_lanes u_lanes (
    .srcVec    (srcVec),
    .dstVec    (dstVec),
    .strobes   (strobes),
    .mergedVec (mergedVec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resultVec <= '0;
    else        resultVec <= mergedVec;
  end
endmodule

// File: rtl/vsi_check.sv
module vsi_check
  import vsi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [VEC_W-1:0]   srcVec,
  input logic [VEC_W-1:0]   dstVec,
  input logic [CODE_W-1:0]  laneCode,
  input logic [SHIFT_W-1:0] shiftImm,
  input logic               shiftRight,
  input logic               wide,
  input logic               scalarMode,
  input logic [VEC_W-1:0]   resultVec
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  a_r8_reset_zero: assert property (@(posedge clk)
    !rst_n |-> resultVec == '0);

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (!$past(wide) || $past(scalarMode))) |-> resultVec[VEC_W-1:HALF_W] == '0);

  a_r2_zero_left: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!shiftRight && shiftImm == '0 && wide && !scalarMode))
      |-> resultVec == $past(srcVec));

  a_r4_full_right: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(shiftRight && laneCode == 2'd3 && shiftImm == 7'd64 && wide && !scalarMode))
      |-> resultVec == $past(dstVec));

  a_r1_low_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!shiftRight && laneCode == 2'd3 && shiftImm < 7'd64))
      |-> ((resultVec[63:0] ^ $past(dstVec[63:0])) & ~(64'hFFFF_FFFF_FFFF_FFFF << $past(shiftImm))) == '0);

  a_r7_scalar_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(scalarMode && laneCode == 2'd0)) |-> resultVec[VEC_W-1:8] == '0);
endmodule

bind vsi_unit vsi_check u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srcVec     (srcVec),
  .dstVec     (dstVec),
  .laneCode   (laneCode),
  .shiftImm   (shiftImm),
  .shiftRight (shiftRight),
  .wide       (wide),
  .scalarMode (scalarMode),
  .resultVec  (resultVec)
);

// File: tb/vsi_unit_tb.sv
module vsi_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] srcVec = '0, dstVec = '0;
  logic [1:0]   laneCode = '0;
  logic [6:0]   shiftImm = '0;
  logic         shiftRight = 1'b0, wide = 1'b1, scalarMode = 1'b0;
  logic [127:0] resultVec;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vsi_unit u_dut (
    .clk(clk), .rst_n(rst_n), .srcVec(srcVec), .dstVec(dstVec),
    .laneCode(laneCode), .shiftImm(shiftImm), .shiftRight(shiftRight),
    .wide(wide), .scalarMode(scalarMode), .resultVec(resultVec)
  );

  function automatic logic [127:0] model(logic [127:0] s0, logic [127:0] d0, int code,
                                         int sh, bit right, bit wd, bit sc);
    int L, n;
    logic [127:0] r, s, d, v, lanePow;
    L = 8 << code;
    n = sc ? 1 : (wd ? 128 / L : 64 / L);
    r = '0;
    lanePow = 128'(1) << L;
    for (int i = 0; i < n; i++) begin
      s = (s0 >> (i * L)) % lanePow;
      d = (d0 >> (i * L)) % lanePow;
      if (!right)
        v = ((s * (128'(1) << sh)) % lanePow) + (d % (128'(1) << sh));
      else
        v = (s / (128'(1) << sh)) + (d - (d % (128'(1) << (L - sh))));
      r = r | (v << (i * L));
    end
    return r;
  endfunction

  task automatic compare(string tag, logic [127:0] got, logic [127:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic applyOne(logic [127:0] s, logic [127:0] d, int code, int sh,
                          bit right, bit wd, bit sc);
    string tag;
    @(negedge clk);
    srcVec = s; dstVec = d; laneCode = 2'(code); shiftImm = 7'(sh);
    shiftRight = right; wide = wd; scalarMode = sc;
    @(negedge clk);
    if (sc)                   tag = "R7";
    else if (!wd)             tag = "R6";
    else if (!right && sh==0) tag = "R2";
    else if (right && sh == (8 << code)) tag = "R4";
    else if (right)           tag = "R3";
    else                      tag = "R1";
    tag = {"R5 ", tag};
    compare(tag, resultVec, model(s, d, code, sh, right, wd, sc));
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [127:0] ps [3];
    logic [127:0] pd [3];
    ps[0] = '1; pd[0] = '0;
    ps[1] = '0; pd[1] = '1;
    ps[2] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    pd[2] = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

    srcVec = ps[2]; dstVec = pd[2];
    repeat (3) @(negedge clk);
    compare("R8 reset", resultVec, '0);
    rst_n = 1'b1;

    // R8: one-cycle latency after reset release
    applyOne(ps[2], pd[2], 1, 5, 1'b0, 1'b1, 1'b0);

    for (int code = 0; code < 4; code++)
      for (int right = 0; right < 2; right++)
        for (int sh = right; sh < (8 << code) + right; sh++)
          for (int m = 0; m < 3; m++)
            for (int p = 0; p < 3; p++)
              applyOne(ps[p], pd[p], code, sh, bit'(right), m != 1, m == 2);

    // R4 overlapping with width clearing: full-width right insert in narrow and scalar modes
    for (int code = 0; code < 4; code++) begin
      applyOne(ps[2], pd[2], code, 8 << code, 1'b1, 1'b0, 1'b0);
      applyOne(ps[2], pd[2], code, 8 << code, 1'b1, 1'b1, 1'b1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule